// File: doc/BRIEF.md
# Dual-Copy SECDED Memory Scrubber

This block keeps one logical memory of 64-bit words in two physical copies. Each copy stores every word as a 72-bit SECDED codeword. A user port gives single-cycle synchronous access. A write is encoded once and stored in both copies at the same address. A read decodes both copies and returns corrected data one cycle later. The read prefers the first copy and takes the second copy only when the first holds a word it cannot correct.

Every cycle in which the user port is idle, a background engine takes one address from a scrub pointer. It decodes both copies in that cycle. A copy with a single-bit error is rewritten at once with the corrected word. A copy with a double-bit error is rewritten from the other copy when that copy is readable. When both copies hold double errors, the word is counted as uncorrectable and both copies are left untouched. The pointer runs from address 0 to the last address and then starts again at 0. It holds still whenever the user port is busy. Three saturating counters report the repairs.

Top module: `ecc_dual_scrub`

## Requirements
- R1: After a synchronous active-low reset, all three counters read 0, `rsp_valid` is low, and every stored word decodes as all-zero data with no error.
- R2: A write with `req_valid=1, req_write=1` stores the word in both copies. A read with `req_valid=1, req_write=0` raises `rsp_valid` on the next clock, with the stored data on `rsp_rdata`. `rsp_valid` is low in every other cycle.
- R3: A read of a word whose first copy has exactly one flipped bit, among all 72 stored bits, returns the original data with `rsp_fixed=1` and `rsp_alt=0`.
- R4: A read of a word whose first copy has two flipped bits and whose second copy has at most one returns the original data with `rsp_alt=1`. `rsp_fixed` is 1 exactly when the second copy had one flipped bit.
- R5: A read of a word with two flipped bits in both copies returns `rsp_fatal=1`, `rsp_fixed=0` and `rsp_alt=0`.
- R6: When the scrubber visits a word, `cnt_single` increases by the number of copies that hold exactly one flipped bit. Those copies are rewritten corrected, so a later read shows no correction.
- R7: When the scrubber visits a word where exactly one copy holds two flipped bits, `cnt_double` increases by 1. That copy is rewritten from the other copy, so a later read returns the data from the first copy without `rsp_alt`.
- R8: When the scrubber visits a word where both copies hold two flipped bits, `cnt_fatal` increases by 1. Neither copy is changed, so later reads still report `rsp_fatal` and later passes count the word again.
- R9: The scrubber visits one address in each cycle without a user request and none in a cycle with one. Visits go in ascending address order, and the pointer does not advance during user cycles.
- R10: After the visit to the last address, the next visit is to address 0.
- R11: The counters saturate at 2^CNT_W-1 and never decrease except at reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | User access this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Word address, AW = clog2(DEPTH) |
| req_wdata | input | 64 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after a read |
| rsp_rdata | output | 64 | Corrected read data |
| rsp_fixed | output | 1 | Returned copy needed a single-bit correction |
| rsp_alt | output | 1 | Data came from the second copy |
| rsp_fatal | output | 1 | Both copies uncorrectable; data meaningless |
| cnt_single | output | CNT_W | Corrected single-bit errors |
| cnt_double | output | CNT_W | Double errors recovered from the other copy |
| cnt_fatal | output | CNT_W | Uncorrectable word visits |

## Verification
A wrong scrub pointer, or a repair that was skipped or aimed at the wrong copy, changes the counters. The change shows either in the cycle of the visit or on the next pass, which comes at most DEPTH idle cycles later. A corrupted stored word shows up on the next read of that address through `rsp_fixed`, `rsp_alt` or `rsp_fatal`, one clock after the request. The reference model therefore tracks the flip count of every copy and the pointer position every clock. It compares all counters and responses every clock, so a divergence is reported in the cycle where it first appears.

// File: rtl/ecc_dual_scrub_pkg.sv
// Package: SECDED (72,64) code shared by the scrubber.
// Codeword layout: bit 0 is the overall parity, bits 1..71 form a Hamming
// code with check bits at the power-of-two positions.
package ecc_dual_scrub_pkg;
    localparam int DW = 64;
    localparam int CW = 72;
    localparam int SYN_W = 7;

    typedef struct packed {
        logic [DW-1:0] data;
        logic          single;
        logic          dbl;
    } dec_t;

    // Build a codeword from a data word.
    function automatic logic [CW-1:0] ecc_encode(input logic [DW-1:0] d);
        logic [CW-1:0] cw;
        int k;
        cw = '0;
        k = 0;
        for (int p = 1; p < CW; p++) begin
            if ((p & (p - 1)) != 0) begin
                cw[p] = d[k];
                k++;
            end
        end
        for (int b = 0; b < SYN_W; b++) begin
            logic x;
            x = 1'b0;
            for (int p = 1; p < CW; p++) begin
                if ((p & (1 << b)) != 0) x = x ^ cw[p];
            end
            cw[1 << b] = x;
        end
        cw[0] = ^cw[CW-1:1];
        return cw;
    endfunction

    // Check a codeword, correct one flipped bit, flag two.
    function automatic dec_t ecc_decode(input logic [CW-1:0] cw);
        dec_t r;
        logic [SYN_W-1:0] syn;
        logic ov;
        logic [CW-1:0] fx;
        int k;
        syn = '0;
        for (int p = 1; p < CW; p++) begin
            if (cw[p]) syn = syn ^ SYN_W'(p);
        end
        ov = ^cw;
        fx = cw;
        r.single = 1'b0;
        r.dbl = 1'b0;
        r.data = '0;
        if (ov) begin
            if (int'(syn) >= CW) begin
                r.dbl = 1'b1;
            end else begin
                r.single = 1'b1;
                if (syn != '0) fx[syn] = ~fx[syn];
            end
        end else if (syn != '0) begin
            r.dbl = 1'b1;
        end
        k = 0;
        for (int p = 1; p < CW; p++) begin
            if ((p & (p - 1)) != 0) begin
                r.data[k] = fx[p];
                k++;
            end
        end
        return r;
    endfunction
endpackage

// File: rtl/ecc_bank.sv
// Module: ecc_bank
// One copy of the codeword store. Read is combinational at addr and write
// is synchronous at the same addr. Reset clears all words to the all-zero
// codeword, which is valid.
// Assumes DEPTH is small enough for a reset loop over the array.
module ecc_bank #(
    parameter int DEPTH = 32,
    parameter int W     = 72,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] mem [DEPTH];

    // Storage: clear on reset, otherwise write the selected word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[addr] <= wdata;
        end
    end

    // Asynchronous read of the addressed word.
    assign rdata = mem[addr];
endmodule

// File: rtl/sat_counter.sv
// Module: sat_counter
// Adds 0..3 per cycle and stops at the all-ones value.
module sat_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       inc,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W+1:0] MAXV = {2'b00, {CNT_W{1'b1}}};
    logic [CNT_W+1:0] sum;

    // Widened sum so a carry past the top is visible.
    assign sum = {2'b00, count} + {{CNT_W{1'b0}}, inc};

    // Saturating update.
    always_ff @(posedge clk) begin
        if (!rst_n) count <= '0;
        else        count <= (sum > MAXV) ? MAXV[CNT_W-1:0] : sum[CNT_W-1:0];
    end
endmodule

// File: rtl/ecc_dual_scrub.sv
// Module: ecc_dual_scrub
// Duplicated SECDED memory with a user port and an idle-cycle scrubber.
// The user port has priority. In an idle cycle the scrub pointer addresses
// both copies, and any repair is written back in that same cycle.
// Assumes DEPTH >= 2 and at most two flipped bits per stored word.
module ecc_dual_scrub
    import ecc_dual_scrub_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int CNT_W = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [AW-1:0]    req_addr,
    input  logic [DW-1:0]    req_wdata,
    output logic             rsp_valid,
    output logic [DW-1:0]    rsp_rdata,
    output logic             rsp_fixed,
    output logic             rsp_alt,
    output logic             rsp_fatal,
    output logic [CNT_W-1:0] cnt_single,
    output logic [CNT_W-1:0] cnt_double,
    output logic [CNT_W-1:0] cnt_fatal
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [AW-1:0] scrub_ptr;
    logic [AW-1:0] acc_addr;
    logic          idle;
    logic [CW-1:0] rd_cw [2];
    dec_t          dec   [2];
    logic          we    [2];
    logic [DW-1:0] good_data;
    logic [CW-1:0] wr_cw;
    logic          both_bad;
    logic [1:0]    inc_single, inc_double, inc_fatal;

    assign idle     = !req_valid;
    assign acc_addr = req_valid ? req_addr : scrub_ptr;
    assign both_bad = dec[0].dbl & dec[1].dbl;
    assign good_data = dec[0].dbl ? dec[1].data : dec[0].data;
    assign wr_cw    = ecc_encode(req_valid ? req_wdata : good_data);

    // Two copies, each with its decoder and repair-enable logic.
    for (genvar g = 0; g < 2; g++) begin : g_copy
        localparam int O = 1 - g;
        ecc_bank #(.DEPTH(DEPTH), .W(CW)) u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (we[g]),
            .addr  (acc_addr),
            .wdata (wr_cw),
            .rdata (rd_cw[g])
        );
        assign dec[g] = ecc_decode(rd_cw[g]);
        assign we[g]  = req_valid ? req_write
                                  : (dec[g].single | (dec[g].dbl & !dec[O].dbl));
    end

    // Event counts for the scrub visit of this cycle.
    always_comb begin
        inc_single = 2'd0;
        inc_double = 2'd0;
        inc_fatal  = 2'd0;
        if (idle) begin
            inc_single = {1'b0, dec[0].single} + {1'b0, dec[1].single};
            inc_double = {1'b0, dec[0].dbl & !dec[1].dbl} + {1'b0, dec[1].dbl & !dec[0].dbl};
            inc_fatal  = {1'b0, both_bad};
        end
    end

    // Scrub pointer: advances and wraps on idle cycles only.
    always_ff @(posedge clk) begin
        if (!rst_n)    scrub_ptr <= '0;
        else if (idle) scrub_ptr <= (scrub_ptr == LAST) ? '0 : scrub_ptr + 1'b1;
    end

    // Read response register, one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
            rsp_fixed <= 1'b0;
            rsp_alt   <= 1'b0;
            rsp_fatal <= 1'b0;
        end else begin
            rsp_valid <= req_valid & !req_write;
            rsp_fixed <= 1'b0;
            rsp_alt   <= 1'b0;
            rsp_fatal <= 1'b0;
            if (req_valid && !req_write) begin
                rsp_rdata <= good_data;
                rsp_fixed <= dec[0].dbl ? (dec[1].single & !dec[1].dbl) : dec[0].single;
                rsp_alt   <= dec[0].dbl & !dec[1].dbl;
                rsp_fatal <= both_bad;
            end
        end
    end

    sat_counter #(.CNT_W(CNT_W)) u_cnt_single (
        .clk(clk), .rst_n(rst_n), .inc(inc_single), .count(cnt_single));
    sat_counter #(.CNT_W(CNT_W)) u_cnt_double (
        .clk(clk), .rst_n(rst_n), .inc(inc_double), .count(cnt_double));
    sat_counter #(.CNT_W(CNT_W)) u_cnt_fatal (
        .clk(clk), .rst_n(rst_n), .inc(inc_fatal), .count(cnt_fatal));
endmodule

// File: rtl/ecc_dual_scrub_chk.sv
// Module: ecc_dual_scrub_chk
// Port-level properties of the scrubber, attached to every instance by bind.
module ecc_dual_scrub_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_write,
    input logic             rsp_valid,
    input logic             rsp_fixed,
    input logic             rsp_fatal,
    input logic [CNT_W-1:0] cnt_single,
    input logic [CNT_W-1:0] cnt_double,
    input logic [CNT_W-1:0] cnt_fatal
);
    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (cnt_single == '0 && cnt_double == '0 && cnt_fatal == '0 && !rsp_valid));

    // R2
    read_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> rsp_valid);

    // R2
    no_stray_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && !req_write) |=> !rsp_valid);

    // R5
    fatal_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fatal |-> !rsp_fixed);

    // R9
    user_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> ($stable(cnt_single) && $stable(cnt_double) && $stable(cnt_fatal)));

    // R11
    monotonic_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (cnt_single >= $past(cnt_single) && cnt_double >= $past(cnt_double)
                  && cnt_fatal >= $past(cnt_fatal)));
endmodule

bind ecc_dual_scrub ecc_dual_scrub_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .rsp_valid  (rsp_valid),
    .rsp_fixed  (rsp_fixed),
    .rsp_fatal  (rsp_fatal),
    .cnt_single (cnt_single),
    .cnt_double (cnt_double),
    .cnt_fatal  (cnt_fatal)
);

// File: tb/ecc_dual_scrub_test.sv
// Bench: a behavioural model tracks flipped-bit counts per copy and address,
// the scrub pointer and the counters, and is compared on every clock.
module ecc_dual_scrub_test;
    localparam int DEPTH = 16;
    localparam int CNT_W = 4;
    localparam int AW    = $clog2(DEPTH);
    localparam int CMAX  = (1 << CNT_W) - 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic             req_write = 1'b0;
    logic [AW-1:0]    req_addr = '0;
    logic [63:0]      req_wdata = '0;
    logic             rsp_valid, rsp_fixed, rsp_alt, rsp_fatal;
    logic [63:0]      rsp_rdata;
    logic [CNT_W-1:0] cnt_single, cnt_double, cnt_fatal;

    always #5 clk = ~clk;

    ecc_dual_scrub #(.DEPTH(DEPTH), .CNT_W(CNT_W)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata), .rsp_fixed(rsp_fixed), .rsp_alt(rsp_alt),
        .rsp_fatal(rsp_fatal), .cnt_single(cnt_single), .cnt_double(cnt_double),
        .cnt_fatal(cnt_fatal));

    int n_chk = 0;
    int n_fail = 0;
    logic [63:0] m_data [DEPTH];
    int m_ea [DEPTH];
    int m_eb [DEPTH];
    int m_ptr, m_single, m_double, m_fatal;
    bit e_valid, e_fixed, e_alt, e_fatal;
    logic [63:0] e_data;
    string ctx = "";

    function automatic int sat(input int v);
        return (v > CMAX) ? CMAX : v;
    endfunction

    function automatic logic [63:0] pat(input int i);
        return {32'(i) * 32'h9E3779B9, ~(32'(i) * 32'h01000193)};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, ctx, act, exp);
        end
    endtask

    // Model update for one rising edge with the inputs held by the bench.
    task automatic model_edge();
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                m_data[i] = '0; m_ea[i] = 0; m_eb[i] = 0;
            end
            m_ptr = 0; m_single = 0; m_double = 0; m_fatal = 0;
            e_valid = 0; e_fixed = 0; e_alt = 0; e_fatal = 0;
        end else if (req_valid) begin
            e_valid = 0; e_fixed = 0; e_alt = 0; e_fatal = 0;
            if (req_write) begin
                m_data[req_addr] = req_wdata;
                m_ea[req_addr] = 0;
                m_eb[req_addr] = 0;
            end else begin
                int a = int'(req_addr);
                e_valid = 1;
                e_data = m_data[a];
                if (m_ea[a] < 2) begin
                    e_fixed = (m_ea[a] == 1);
                end else if (m_eb[a] < 2) begin
                    e_alt = 1;
                    e_fixed = (m_eb[a] == 1);
                end else begin
                    e_fatal = 1;
                end
            end
        end else begin
            int a = m_ptr;
            bit da = (m_ea[a] >= 2);
            bit db = (m_eb[a] >= 2);
            e_valid = 0; e_fixed = 0; e_alt = 0; e_fatal = 0;
            m_single = sat(m_single + int'(m_ea[a] == 1) + int'(m_eb[a] == 1));
            m_double = sat(m_double + int'(da && !db) + int'(db && !da));
            m_fatal  = sat(m_fatal + int'(da && db));
            if (!(da && db)) begin
                m_ea[a] = 0;
                m_eb[a] = 0;
            end
            m_ptr = (m_ptr == DEPTH - 1) ? 0 : m_ptr + 1;
        end
    endtask

    // Compare every output with the model.
    task automatic compare();
        chk(rsp_valid == e_valid, "R2 rsp_valid", 64'(rsp_valid), 64'(e_valid));
        chk(int'(cnt_single) == m_single, "R6/R9/R10/R11 cnt_single", 64'(cnt_single), 64'(m_single));
        chk(int'(cnt_double) == m_double, "R7/R9/R10/R11 cnt_double", 64'(cnt_double), 64'(m_double));
        chk(int'(cnt_fatal) == m_fatal, "R8/R9/R10/R11 cnt_fatal", 64'(cnt_fatal), 64'(m_fatal));
        if (e_valid) begin
            chk(rsp_fatal == e_fatal, "R5 rsp_fatal", 64'(rsp_fatal), 64'(e_fatal));
            chk(rsp_alt == e_alt, "R4 rsp_alt", 64'(rsp_alt), 64'(e_alt));
            chk(rsp_fixed == e_fixed, "R3 rsp_fixed", 64'(rsp_fixed), 64'(e_fixed));
            if (!e_fatal) chk(rsp_rdata == e_data, "R2 rsp_rdata", rsp_rdata, e_data);
        end
    endtask

    // One clock: drive at the falling edge, update at rise, check at next fall.
    task automatic step(input bit v, input bit w, input int a, input logic [63:0] d);
        req_valid = v;
        req_write = w;
        req_addr  = AW'(a);
        req_wdata = d;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, '0);
    endtask

    // Flip one stored bit of one copy; done at a falling edge.
    task automatic flip(input int c, input int a, input int b);
        if (c == 0) begin
            uut.g_copy[0].u_bank.mem[a][b] = ~uut.g_copy[0].u_bank.mem[a][b];
            m_ea[a]++;
        end else begin
            uut.g_copy[1].u_bank.mem[a][b] = ~uut.g_copy[1].u_bank.mem[a][b];
            m_eb[a]++;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk + 1, n_fail + 1);
        $finish;
    end

    initial begin
        @(negedge clk);
        ctx = "reset R1";
        step(0, 0, 0, '0);
        step(0, 0, 0, '0);
        rst_n = 1'b1;
        // R1: reading a cleared word returns zero with no flag
        step(1, 0, 5, '0);
        step(0, 0, 0, '0);

        ctx = "fill R2";
        for (int i = 0; i < DEPTH; i++) step(1, 1, i, pat(i));
        for (int i = 0; i < DEPTH; i++) step(1, 0, i, '0);
        step(0, 0, 0, '0);

        ctx = "read faults R3 R4 R5";
        flip(0, 3, 17); step(1, 0, 3, '0);
        flip(0, 5, 0); flip(0, 5, 40); step(1, 0, 5, '0);
        flip(0, 7, 2); flip(0, 7, 71); flip(1, 7, 9); flip(1, 7, 33); step(1, 0, 7, '0);
        flip(0, 9, 4); flip(0, 9, 64); flip(1, 9, 1); step(1, 0, 9, '0);
        flip(1, 11, 50); step(1, 0, 11, '0);

        ctx = "scrub repair R6 R7 R8 R10";
        idle(2 * DEPTH + 3);
        for (int i = 3; i <= 11; i += 2) step(1, 0, i, '0);

        ctx = "stall R9";
        flip(0, 2, 30); flip(1, 13, 6); flip(1, 13, 7);
        for (int i = 0; i < 3 * DEPTH; i++) step(i % 3 == 0, 0, i % DEPTH, '0);
        idle(DEPTH);

        ctx = "saturate R11";
        idle(CMAX * DEPTH + DEPTH);
        chk(m_fatal == CMAX, "R11 model saturated", 64'(m_fatal), 64'(CMAX));
        flip(0, 0, 10); flip(1, 1, 11); flip(0, 4, 12); flip(0, 4, 13);
        idle(DEPTH * 2);

        ctx = "rewrite R2 R8";
        step(1, 0, 7, '0);
        step(1, 1, 7, 64'hDEAD_BEEF_0BAD_F00D);
        step(1, 0, 7, '0);
        idle(DEPTH + 2);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule